// File: doc/BRIEF.md
# Bit-Plane Counter Multi-Channel PWM

This block drives several pulse-width-modulated outputs from a bank of small down counters. The counters are not stored one per register. Each register holds one bit position of every counter, so register n carries bit n of all counters side by side. Half of the counters are "turn-on" counters and the other half are "turn-off" counters, one of each per output channel. A single step strobe advances every counter at the same time. A shared carry chain made of XOR and AND gates, one stage per bit plane, finds which counters wrapped on that step. Those wrap flags then set or clear the registered output bits.

Software or a neighbouring block sets up each channel by preloading its two counters. The channel's period is 2^CNT_W steps. Its high time is the difference between the turn-off preload and the turn-on preload, taken modulo 2^CNT_W. The step strobe usually comes from a divided tick, so the output frequency is the tick rate divided by 2^CNT_W.

Top module: `slice_pwm`

## Requirements
- R1: While rst_n is low, every counter is cleared to zero and pwmOut is all zeros.
- R2: On each clock edge where stepEn is high and loadEn is low, every counter decrements by one modulo 2^CNT_W. A counter wraps (raises its wrap flag) on the step where its value was 0 before the step.
- R3: Counter index i, for i from 0 to NUM_CH-1, is the turn-on counter of channel i. When it wraps, pwmOut[i] becomes 1 at that same clock edge.
- R4: Counter index NUM_CH+i is the turn-off counter of channel i. When it wraps, pwmOut[i] becomes 0 at that same edge. If both counters of a channel wrap on the same step, the output becomes 0.
- R5: On a clock edge where stepEn is low, no counter changes and pwmOut holds its value.
- R6: On an edge where loadEn is high, counter loadSel takes the value loadVal. Every other counter keeps its value.
- R7: When loadEn and stepEn are both high, the load takes effect, no counter steps, and pwmOut holds.
- R8: Channel i stays high for ((F-R) mod 2^CNT_W) steps of every 2^CNT_W-step period, where R and F are the preloads of its turn-on and turn-off counters. Equal preloads give a constant low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stepEn | input | 1 | Advance all counters by one step |
| loadEn | input | 1 | Write loadVal into counter loadSel |
| loadSel | input | $clog2(2*NUM_CH) | Counter index (0..NUM_CH-1 turn-on, NUM_CH.. turn-off) |
| loadVal | input | CNT_W | Preload value |
| pwmOut | output | NUM_CH | Registered PWM outputs |

## Verification
The bench first lets zero-valued counters wrap together. A design that applied the set after the clear would raise every output at that point instead of holding them low. It then times the first rising and falling edges after a preload to the exact step. A carry chain that counted up, or that wrapped one step early or late, shifts these edges. Duty is measured over full periods, including the equal-preload case and the case where F minus R is negative. This exposes a subtraction that is not taken modulo the period. Loads that arrive together with a step, and steps separated by idle cycles, are checked against a reference model. A design that let the step win over the load, or that advanced without a step, would fall out of step with the model.

// File: rtl/slice_pwm_pkg.sv
package slice_pwm_pkg;
  typedef struct packed {
    logic advance;
    logic load;
  } ctlStrobe_t;
endpackage

// File: rtl/slice_pwm_ctl.sv
module slice_pwm_ctl
  import slice_pwm_pkg::*;
#(
  parameter int NUM_CH  = 4,
  localparam int NUM_CTR = 2 * NUM_CH,
  localparam int SEL_W   = $clog2(NUM_CTR)
) (
  input  logic               stepEn,
  input  logic               loadEn,
  input  logic [SEL_W-1:0]   loadSel,
  output ctlStrobe_t         strobe,
  output logic [NUM_CTR-1:0] loadMask
);
  // a preload wins over a step in the same cycle
  always_comb begin
    strobe.load    = loadEn;
    strobe.advance = stepEn && !loadEn;
  end

  always_comb begin
    loadMask = '0;
    for (int c = 0; c < NUM_CTR; c++) begin
      if (loadEn && (int'(loadSel) == c)) loadMask[c] = 1'b1;
    end
  end
endmodule

// File: rtl/slice_pwm_dp.sv
module slice_pwm_dp
  import slice_pwm_pkg::*;
#(
  parameter int CNT_W   = 5,
  parameter int NUM_CH  = 4,
  localparam int NUM_CTR = 2 * NUM_CH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctlStrobe_t         strobe,
  input  logic [NUM_CTR-1:0] loadMask,
  input  logic [CNT_W-1:0]   loadVal,
  output logic [NUM_CTR-1:0] rollMask,
  output logic [NUM_CH-1:0]  pwmOut
);
  logic [CNT_W-1:0][NUM_CTR-1:0] plane;
  logic [CNT_W-1:0][NUM_CTR-1:0] planeNext;
  logic [CNT_W:0][NUM_CTR-1:0]   carry;
  logic [NUM_CH-1:0]             pwmState;

  // plane 0 sees an all-ones carry, so it simply inverts
  assign carry[0] = '1;

  for (genvar n = 0; n < CNT_W; n++) begin : g_plane
    // toggle where a borrow arrives; pass on bits that went 0 -> 1
    assign planeNext[n] = plane[n] ^ carry[n];
    assign carry[n+1]   = carry[n] & planeNext[n];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        plane[n] <= '0;
      end else if (strobe.load) begin
        plane[n] <= (plane[n] & ~loadMask) | (loadMask & {NUM_CTR{loadVal[n]}});
      end else if (strobe.advance) begin
        plane[n] <= planeNext[n];
      end
    end
  end

  assign rollMask = carry[CNT_W];

  // the clear from a turn-off counter is applied after the set
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwmState <= '0;
    end else if (strobe.advance) begin
      pwmState <= (pwmState | rollMask[NUM_CH-1:0]) & ~rollMask[NUM_CTR-1:NUM_CH];
    end
  end

  assign pwmOut = pwmState;
endmodule

// File: rtl/slice_pwm.sv
module slice_pwm
  import slice_pwm_pkg::*;
#(
  parameter int CNT_W  = 5,
  parameter int NUM_CH = 4,
  localparam int NUM_CTR = 2 * NUM_CH,
  localparam int SEL_W   = $clog2(NUM_CTR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stepEn,
  input  logic              loadEn,
  input  logic [SEL_W-1:0]  loadSel,
  input  logic [CNT_W-1:0]  loadVal,
  output logic [NUM_CH-1:0] pwmOut
);
  ctlStrobe_t         strobe;
  logic [NUM_CTR-1:0] loadMask;
  logic [NUM_CTR-1:0] rollMask;

  slice_pwm_ctl #(.NUM_CH(NUM_CH)) uCtl (
    .stepEn  (stepEn),
    .loadEn  (loadEn),
    .loadSel (loadSel),
    .strobe  (strobe),
    .loadMask(loadMask)
  );

  slice_pwm_dp #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) uDp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .loadMask(loadMask),
    .loadVal (loadVal),
    .rollMask(rollMask),
    .pwmOut  (pwmOut)
  );
endmodule

// File: rtl/slice_pwm_chk.sv
module slice_pwm_chk #(
  parameter int CNT_W  = 5,
  parameter int NUM_CH = 4,
  localparam int NUM_CTR = 2 * NUM_CH
) (
  input logic               clk,
  input logic               rst_n,
  input logic               stepEn,
  input logic               loadEn,
  input logic [NUM_CTR-1:0] loadMask,
  input logic [NUM_CTR-1:0] rollMask,
  input logic [NUM_CH-1:0]  pwmOut
);
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !stepEn |=> $stable(pwmOut));

  p_load_priority_r7: assert property (@(posedge clk) disable iff (!rst_n)
    loadEn |=> $stable(pwmOut));

  p_one_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    loadEn |-> $onehot(loadMask));

  p_no_stray_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !loadEn |-> (loadMask == '0));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    p_rise_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (stepEn && !loadEn && rollMask[i] && !rollMask[NUM_CH+i]) |=> pwmOut[i]);

    p_fall_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (stepEn && !loadEn && rollMask[NUM_CH+i]) |=> !pwmOut[i]);
  end
endmodule

bind slice_pwm slice_pwm_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) uChk (
  .clk     (clk),
  .rst_n   (rst_n),
  .stepEn  (stepEn),
  .loadEn  (loadEn),
  .loadMask(loadMask),
  .rollMask(rollMask),
  .pwmOut  (pwmOut)
);

// File: tb/sim_slice_pwm.sv
`timescale 1ns/1ps
module sim_slice_pwm;
  localparam int CW = 5;
  localparam int NC = 4;
  localparam int NT = 2 * NC;
  localparam int MOD = 1 << CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stepEn = 1'b0;
  logic loadEn = 1'b0;
  logic [2:0] loadSel = '0;
  logic [CW-1:0] loadVal = '0;
  logic [NC-1:0] pwmOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string tag = "R1";

  int mdlCnt [NT];
  logic [NC-1:0] mdlOut;

  always #4 clk = ~clk;

  slice_pwm #(.CNT_W(CW), .NUM_CH(NC)) u0 (
    .clk(clk), .rst_n(rst_n), .stepEn(stepEn), .loadEn(loadEn),
    .loadSel(loadSel), .loadVal(loadVal), .pwmOut(pwmOut)
  );

  // behavioural reference: integer counters and an output vector
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NT; c++) mdlCnt[c] = 0;
      mdlOut = '0;
    end else if (loadEn) begin
      mdlCnt[loadSel] = int'(loadVal);
    end else if (stepEn) begin
      bit wrapped [NT];
      for (int c = 0; c < NT; c++) begin
        wrapped[c] = (mdlCnt[c] == 0);
        mdlCnt[c] = wrapped[c] ? MOD - 1 : mdlCnt[c] - 1;
      end
      for (int i = 0; i < NC; i++) begin
        if (wrapped[NC+i]) mdlOut[i] = 1'b0;
        else if (wrapped[i]) mdlOut[i] = 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    if (!done && rst_n) begin
      checks++;
      if (pwmOut !== mdlOut) begin
        errors++;
        $display("FAIL %s model: pwmOut=%b expected %b", tag, pwmOut, mdlOut);
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic load(input int sel, input int val, input bit withStep);
    loadEn = 1'b1; stepEn = withStep; loadSel = 3'(sel); loadVal = CW'(val);
    @(negedge clk);
    loadEn = 1'b0; stepEn = 1'b0;
  endtask

  task automatic steps(input int n);
    for (int k = 0; k < n; k++) begin
      stepEn = 1'b1;
      @(negedge clk);
    end
    stepEn = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run did not end");
    finishRun();
  end

  initial begin
    int hi [NC];
    int rPre [NC] = '{3, 20, 7, 0};
    int fPre [NC] = '{13, 4, 7, 31};
    logic [NC-1:0] held;
    repeat (3) @(negedge clk);
    check("R1 reset output", 32'(pwmOut), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 32'(pwmOut), 0);

    // all counters at zero wrap together: clear must beat set
    tag = "R4";
    steps(1);
    check("R4 simultaneous wrap stays low", 32'(pwmOut), 0);
    steps(MOD - 1);

    // exact edge timing on channel 0 (all counters back at 0 here)
    tag = "R2";
    load(0, 5, 0);
    load(NC, 20, 0);
    steps(5);
    check("R2 no rise before wrap", 32'(pwmOut[0]), 0);
    steps(1);
    check("R3 rise on wrap step", 32'(pwmOut[0]), 1);
    steps(14);
    check("R4 still high before turn-off", 32'(pwmOut[0]), 1);
    steps(1);
    check("R4 turn-off wrap clears", 32'(pwmOut[0]), 0);

    // idle cycles hold the output
    tag = "R5";
    steps(3);
    held = pwmOut;
    repeat (10) @(negedge clk);
    check("R5 hold without step", 32'(pwmOut), 32'(held));

    // load together with a step: load wins, output holds
    tag = "R7";
    held = pwmOut;
    load(2, 9, 1);
    check("R7 no advance on load cycle", 32'(pwmOut), 32'(held));

    // duty over full periods
    tag = "R8";
    for (int i = 0; i < NC; i++) begin
      load(i, rPre[i], 0);
      load(NC + i, fPre[i], 0);
    end
    steps(MOD);
    for (int i = 0; i < NC; i++) hi[i] = 0;
    for (int k = 0; k < MOD; k++) begin
      stepEn = 1'b1;
      @(negedge clk);
      for (int i = 0; i < NC; i++) hi[i] += int'(pwmOut[i]);
    end
    stepEn = 1'b0;
    for (int i = 0; i < NC; i++)
      check("R8 high steps per period", 32'(hi[i]), 32'(((fPre[i] - rPre[i]) % MOD + MOD) % MOD));

    // random loads, steps and gaps against the model
    tag = "R6";
    for (int k = 0; k < 3000; k++) begin
      int r = int'($urandom_range(0, 99));
      loadEn = (r < 10);
      stepEn = (r >= 5) && (r < 75);
      loadSel = 3'($urandom_range(0, NT - 1));
      loadVal = CW'($urandom_range(0, MOD - 1));
      @(negedge clk);
    end
    loadEn = 1'b0; stepEn = 1'b0;
    @(negedge clk);
    finishRun();
  end
endmodule